// File: doc/BRIEF.md
# UART Host Register Bank with Interrupt Identification

This block is the host-facing register file of a 16450-class serial port. A host reaches eight byte-wide registers through a 3-bit offset with separate write and read strobes. The registers are: a 16-bit baud divisor, an interrupt enable, an interrupt identification, a line control, a modem control, a line status, a modem status and a scratch byte. Read data is registered and returns in the cycle after the read strobe. The block drives one level-sensitive interrupt line. It does not contain the serial shifter, the baud clock, FIFOs or parity generation. Those live next to it and talk to it through simple side ports.

On the transmit side, every data write produces a one-cycle strobe that carries the byte. The transmitter is treated as draining at once, so the holding-empty and transmitter-empty status bits stay set. On the receive side, one byte or one break event is taken through a valid/ready handshake into a single holding register. The block then refuses further input until the host reads that register. The decoded line parameters (divisor, data length, stop bits, parity, break) go out on dedicated outputs. Any change of the break bit is flagged with a pulse.

Offsets 0 and 1 are banked: while line control bit 7 is set, they reach the divisor bytes instead of the data and enable registers. Transmit-empty interrupts depend on a hidden pending flag. Enable writes and data writes arm that flag. A read of the identification register that reports the transmit-empty code clears it.

Top module: `uart_hostregs`

## Requirements
- R1: After reset, offset 5 reads 0x60, offset 2 reads 0x01, offset 6 reads 0xB0, offsets 1, 3 and 4 read 0x00, `irq` is low and `rx_ready` is high.
- R2: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte; `divisor` shows {high, low}. A data write in this state gives no `tx_strobe`, and an offset-1 write leaves the interrupt enable and the pending flag unchanged.
- R3: The interrupt enable keeps write bits 3:0 (upper bits read 0), modem control keeps bits 4:0, and the scratch register at offset 7 keeps all 8 bits.
- R4: Offset 2 reads 0x04 when data-ready (line status bit 0) and enable bit 0 are both set. Otherwise it reads 0x02 when the transmit pending flag and enable bit 1 are both set. Otherwise it reads 0x01.
- R5: `irq` is high exactly when offset 2 would read something other than 0x01.
- R6: A read of offset 2 that returns 0x02 clears the transmit pending flag. A read that returns 0x04 or 0x01 leaves it unchanged.
- R7: A write of the interrupt enable (bank bit clear) sets the transmit pending flag, because holding-empty (line status bit 5) is always set.
- R8: A data write (offset 0, bank bit clear) gives `tx_strobe` high for exactly the next cycle with `tx_byte` equal to the written byte and sets the transmit pending flag. Line status bits 5 and 6 stay set.
- R9: When `rx_valid` and `rx_ready` are both high at a clock edge, a byte is stored and line status bit 0 sets. With `rx_break` high, 0x00 is stored and bits 0 and 4 both set. `rx_ready` is low while bit 0 is set, and offered input is then ignored.
- R10: A read of offset 0 (bank bit clear) returns the stored byte and clears line status bits 0 and 4.
- R11: With modem control bit 4 set, offset 6 reads modem control bits 3:2 at bits 7:6, bit 1 at bit 4, bit 0 at bit 5, and zeros elsewhere. With bit 4 clear, it reads 0xB0.
- R12: Line control drives `data_bits` = bits 1:0 + 5, `two_stop` = bit 2, `parity_en` = bit 3, `parity_even` = bit 4 and `break_en` = bit 6. A write that changes bit 6 gives `break_chg` high for one cycle, together with the new `break_en`.
- R13: Writes to offsets 2, 5 and 6 change no register.
- R14: `reg_rdata` loads in the cycle after a read strobe and holds between reads. A cycle with both strobes high performs only the write, so the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Receive item offered |
| rx_break | input | 1 | Offered item is a break event |
| rx_byte | input | 8 | Offered receive byte |
| rx_ready | output | 1 | Receive holding register empty |
| divisor | output | 16 | Baud divisor |
| data_bits | output | 4 | Character length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| break_en | output | 1 | Break forcing requested |
| break_chg | output | 1 | One-cycle pulse when break_en changes |

## Verification
The bench targets the hidden transmit pending flag. It checks that a read returning the receive code leaves the flag set. If that read cleared the flag, the later transmit-empty report would be lost. It checks that a cycle with both strobes high does not clear the flag. It also checks that offset-1 writes in divisor mode do not arm the flag, which would raise a stray interrupt. Register banking is checked by reading the divisor back and confirming that the enable value survives. The loopback mapping is checked with three modem-control patterns, so any crossed bit shows up. The receive side is checked by offering a byte while the holder is full; an overwrite would replace the unread byte. A break is checked to load zero and to set both status bits.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam logic [REG_W-1:0] IID_NONE = 8'h01;
  localparam logic [REG_W-1:0] IID_THR  = 8'h02;
  localparam logic [REG_W-1:0] IID_RX   = 8'h04;

  localparam int LCTL_BANK  = 7;
  localparam int LCTL_BREAK = 6;
  localparam int MCTL_LOOP  = 4;
endpackage

// File: rtl/uhr_rst_sync.sv
module uhr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/uhr_irq_ctrl.sv
module uhr_irq_ctrl
  import uhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr,
  input  logic             tx_wr,
  input  logic             iid_rd,
  input  logic             thre,
  input  logic             data_ready,
  input  logic             ien_rx,
  input  logic             ien_thr,
  output logic [REG_W-1:0] iid,
  output logic             irq
);
  logic thr_pend_q, thr_pend_d, thr_pend_en;

  // fixed priority: receive data above transmit empty
  always_comb begin
    if (data_ready && ien_rx)     iid = IID_RX;
    else if (thr_pend_q && ien_thr) iid = IID_THR;
    else                            iid = IID_NONE;
  end

  assign irq = (iid != IID_NONE);

  always_comb begin
    thr_pend_en = 1'b0;
    thr_pend_d  = thr_pend_q;
    if (tx_wr || (ien_wr && thre)) begin
      thr_pend_en = 1'b1;
      thr_pend_d  = 1'b1;
    end else if (iid_rd && (iid == IID_THR)) begin
      thr_pend_en = 1'b1;
      thr_pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           thr_pend_q <= 1'b0;
    else if (thr_pend_en) thr_pend_q <= thr_pend_d;
  end

  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    iid_rd && (iid == IID_THR) && !ien_wr && !tx_wr |=> iid != IID_THR); // R6
  AST_IEN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr && thre |=> thr_pend_q); // R7
  AST_TX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> thr_pend_q); // R8
endmodule

// File: rtl/uhr_rx_hold.sv
module uhr_rx_hold
  import uhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_break,
  input  logic [REG_W-1:0] rx_byte,
  input  logic             rbr_rd,
  output logic             rx_ready,
  output logic [REG_W-1:0] rbr,
  output logic             data_ready,
  output logic             brk
);
  logic             take;
  logic             flags_en, rbr_en;
  logic             dr_d, brk_d;
  logic [REG_W-1:0] rbr_d;

  assign rx_ready = !data_ready;
  assign take     = rx_valid && rx_ready;

  always_comb begin
    rbr_en   = take;
    rbr_d    = rx_break ? '0 : rx_byte;
    flags_en = take || rbr_rd;
    dr_d     = take;
    brk_d    = take && rx_break;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready <= 1'b0;
      brk        <= 1'b0;
    end else if (flags_en) begin
      data_ready <= dr_d;
      brk        <= brk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rbr <= '0;
    else if (rbr_en) rbr <= rbr_d;
  end

  AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> data_ready); // R9
  AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && rx_break |=> (rbr == '0) && brk); // R9
  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd && !take |=> !data_ready && !brk); // R10
endmodule

// File: rtl/uhr_modem_view.sv
module uhr_modem_view
  import uhr_pkg::*;
#(
  parameter int               MCTL_BITS = 5,
  parameter logic [REG_W-1:0] MSTAT_RST = 8'hB0
) (
  input  logic [MCTL_BITS-1:0] mctl,
  output logic [REG_W-1:0]     view
);
  always_comb begin
    if (mctl[MCTL_LOOP]) begin
      view    = '0;
      view[7] = mctl[3];
      view[6] = mctl[2];
      view[5] = mctl[0];
      view[4] = mctl[1];
    end else begin
      view = MSTAT_RST;
    end
  end
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uhr_pkg::*;
#(
  parameter int               IEN_BITS    = 4,
  parameter int               MCTL_BITS   = 5,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] MSTAT_RST   = 8'hB0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq,
  output logic                 tx_strobe,
  output logic [REG_W-1:0]     tx_byte,
  input  logic                 rx_valid,
  input  logic                 rx_break,
  input  logic [REG_W-1:0]     rx_byte,
  output logic                 rx_ready,
  output logic [2*REG_W-1:0]   divisor,
  output logic [3:0]           data_bits,
  output logic                 two_stop,
  output logic                 parity_en,
  output logic                 parity_even,
  output logic                 break_en,
  output logic                 break_chg
);
  localparam int IEN_PAD  = REG_W - IEN_BITS;
  localparam int MCTL_PAD = REG_W - MCTL_BITS;

  logic rst_q_n;
  uhr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // storage
  logic [REG_W-1:0]     div_lo_q, div_hi_q, lctl_q, scr_q, rdata_q, tx_byte_q;
  logic [IEN_BITS-1:0]  ien_q;
  logic [MCTL_BITS-1:0] mctl_q;
  logic                 tx_strobe_q, brk_chg_q;

  // decode
  reg_ofs_e ofs;
  logic bank, rd_fire;
  logic wr_data, wr_dlo, wr_dhi, wr_ien, wr_lctl, wr_mctl, wr_scr;
  logic rd_rbr, rd_iid;

  assign ofs     = reg_ofs_e'(reg_addr);
  assign bank    = lctl_q[LCTL_BANK];
  assign rd_fire = reg_rd && !reg_wr;

  always_comb begin
    wr_data = reg_wr && (ofs == OFS_DATA) && !bank;
    wr_dlo  = reg_wr && (ofs == OFS_DATA) &&  bank;
    wr_ien  = reg_wr && (ofs == OFS_IEN)  && !bank;
    wr_dhi  = reg_wr && (ofs == OFS_IEN)  &&  bank;
    wr_lctl = reg_wr && (ofs == OFS_LCTL);
    wr_mctl = reg_wr && (ofs == OFS_MCTL);
    wr_scr  = reg_wr && (ofs == OFS_SCR);
    rd_rbr  = rd_fire && (ofs == OFS_DATA) && !bank;
    rd_iid  = rd_fire && (ofs == OFS_IID);
  end

  // receive holder
  logic [REG_W-1:0] rbr;
  logic             data_ready, rx_brk;
  uhr_rx_hold u_rx (
    .clk(clk), .rst_n(rst_q_n), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_byte(rx_byte), .rbr_rd(rd_rbr), .rx_ready(rx_ready), .rbr(rbr),
    .data_ready(data_ready), .brk(rx_brk));

  // line status: transmit side drains at once, so both empty bits stay set
  logic             thre;
  logic [REG_W-1:0] lstat;
  assign thre  = 1'b1;
  assign lstat = {1'b0, 1'b1, thre, rx_brk, 3'b000, data_ready};

  // interrupt identification
  logic [REG_W-1:0] iid;
  uhr_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_q_n), .ien_wr(wr_ien), .tx_wr(wr_data),
    .iid_rd(rd_iid), .thre(thre), .data_ready(data_ready),
    .ien_rx(ien_q[0]), .ien_thr(ien_q[1]), .iid(iid), .irq(irq));

  // modem status view
  logic [REG_W-1:0] mstat_view;
  uhr_modem_view #(.MCTL_BITS(MCTL_BITS), .MSTAT_RST(MSTAT_RST)) u_modem (
    .mctl(mctl_q), .view(mstat_view));

  // config registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      ien_q    <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
    end else if (!rst_q_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      ien_q    <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
    end else begin
      if (wr_dlo)  div_lo_q <= reg_wdata;
      if (wr_dhi)  div_hi_q <= reg_wdata;
      if (wr_ien)  ien_q    <= reg_wdata[IEN_BITS-1:0];
      if (wr_lctl) lctl_q   <= reg_wdata;
      if (wr_mctl) mctl_q   <= reg_wdata[MCTL_BITS-1:0];
      if (wr_scr)  scr_q    <= reg_wdata;
    end
  end

  // transmit strobe and break-change pulse
  logic brk_chg_d;
  assign brk_chg_d = wr_lctl && (reg_wdata[LCTL_BREAK] != lctl_q[LCTL_BREAK]);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tx_strobe_q <= 1'b0;
      brk_chg_q   <= 1'b0;
    end else begin
      tx_strobe_q <= wr_data;
      brk_chg_q   <= brk_chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     tx_byte_q <= '0;
    else if (wr_data) tx_byte_q <= reg_wdata;
  end

  // read path
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    unique case (ofs)
      OFS_DATA:  rd_mux = bank ? div_lo_q : rbr;
      OFS_IEN:   rd_mux = bank ? div_hi_q : {{IEN_PAD{1'b0}}, ien_q};
      OFS_IID:   rd_mux = iid;
      OFS_LCTL:  rd_mux = lctl_q;
      OFS_MCTL:  rd_mux = {{MCTL_PAD{1'b0}}, mctl_q};
      OFS_LSTAT: rd_mux = lstat;
      OFS_MSTAT: rd_mux = mstat_view;
      OFS_SCR:   rd_mux = scr_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
  end

  // outputs
  assign reg_rdata   = rdata_q;
  assign tx_strobe   = tx_strobe_q;
  assign tx_byte     = tx_byte_q;
  assign break_chg   = brk_chg_q;
  assign divisor     = {div_hi_q, div_lo_q};
  assign data_bits   = {2'b00, lctl_q[1:0]} + 4'd5;
  assign two_stop    = lctl_q[2];
  assign parity_en   = lctl_q[3];
  assign parity_even = lctl_q[4];
  assign break_en    = lctl_q[LCTL_BREAK];

  AST_TX_SOURCE: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_strobe |-> $past(reg_wr && (reg_addr == 3'd0) && !bank)); // R8
  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_wr && (reg_addr == 3'd0) && bank |=> !tx_strobe); // R2
  AST_BRK_EDGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    break_chg |-> (break_en != $past(break_en))); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(reg_rd && !reg_wr) |=> $stable(reg_rdata)); // R14
  AST_LOOP_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    mctl_q[MCTL_LOOP] |-> (mstat_view[3:0] == 4'h0)); // R11
endmodule

// File: tb/uart_hostregs_test.sv
module uart_hostregs_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, tx_byte, rx_byte;
  logic       reg_wr, reg_rd, irq, tx_strobe, rx_valid, rx_break, rx_ready;
  logic [15:0] divisor;
  logic [3:0] data_bits;
  logic       two_stop, parity_en, parity_even, break_en, break_chg;

  always #10 clk = ~clk; // 50 MHz

  uart_hostregs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_break(rx_break), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .divisor(divisor), .data_bits(data_bits), .two_stop(two_stop),
    .parity_en(parity_en), .parity_even(parity_even), .break_en(break_en),
    .break_chg(break_chg));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] exp;
    logic [2:0] addr;
    string      tag;
  } rd_item_t;
  rd_item_t sb[$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data one cycle after each read strobe
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= reg_rd && !reg_wr;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb.size() == 0) begin
        chk("R14 unexpected read", {8'h00, reg_rdata}, 16'hFFFF);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        chk(it.tag, {8'h00, reg_rdata}, {8'h00, it.exp});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = exp; it.addr = a; it.tag = tag;
    sb.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] d, input logic b);
    @(negedge clk);
    rx_byte = d; rx_break = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    rx_valid = 1'b0; rx_break = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rx_ready", {15'd0, rx_ready}, 16'd1);
    rd(3'd5, 8'h60, "R1 line status");
    rd(3'd2, 8'h01, "R1 interrupt id");
    rd(3'd6, 8'hB0, "R1 modem status");
    rd(3'd1, 8'h00, "R1 enable");
    rd(3'd3, 8'h00, "R1 line control");
    rd(3'd4, 8'h00, "R1 modem control");

    // R3 scratch and masks, R14 hold
    wr(3'd7, 8'hA5);
    rd(3'd7, 8'hA5, "R3 scratch");
    repeat (2) @(negedge clk);
    chk("R14 rdata holds", {8'h00, reg_rdata}, 16'h00A5);
    wr(3'd1, 8'hFF);                          // R7 arms pending
    rd(3'd1, 8'h0F, "R3 enable mask");
    chk("R5 irq on transmit empty", {15'd0, irq}, 16'd1);
    rd(3'd2, 8'h02, "R4 transmit-empty id");
    chk("R6 irq after id read", {15'd0, irq}, 16'd0);
    rd(3'd2, 8'h01, "R6 pending cleared");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R3 modem control mask");

    // R11 loopback
    rd(3'd6, 8'hF0, "R11 loop all");
    wr(3'd4, 8'h11);
    rd(3'd6, 8'h20, "R11 loop bit0");
    wr(3'd4, 8'h16);
    rd(3'd6, 8'h50, "R11 loop bits2,1");
    wr(3'd4, 8'h0F);
    rd(3'd6, 8'hB0, "R11 loop off");

    // R2 divisor banking
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk("R2 no strobe in bank", {15'd0, tx_strobe}, 16'd0);
    wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    chk("R2 no arm in bank", {15'd0, irq}, 16'd0);
    rd(3'd0, 8'h34, "R2 divisor low");
    rd(3'd1, 8'h12, "R2 divisor high");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h0F, "R2 enable kept");

    // R12 line decode
    wr(3'd3, 8'h1F);
    chk("R12 data bits", {12'd0, data_bits}, 16'd8);
    chk("R12 flags", {12'd0, two_stop, parity_en, parity_even, break_en}, 16'b1110);
    wr(3'd3, 8'h40);
    chk("R12 break pulse", {14'd0, break_chg, break_en}, 16'b11);
    chk("R12 five bits", {12'd0, data_bits}, 16'd5);
    @(negedge clk);
    chk("R12 pulse one cycle", {15'd0, break_chg}, 16'd0);
    wr(3'd3, 8'h40);
    chk("R12 no pulse same", {15'd0, break_chg}, 16'd0);
    wr(3'd3, 8'h03);
    chk("R12 break off pulse", {14'd0, break_chg, break_en}, 16'b10);
    rd(3'd3, 8'h03, "R12 line control read");

    // R8 transmit
    wr(3'd0, 8'h5A);
    chk("R8 tx strobe+byte", {7'd0, tx_strobe, tx_byte}, 16'h015A);
    @(negedge clk);
    chk("R8 strobe one cycle", {15'd0, tx_strobe}, 16'd0);
    chk("R8 irq armed", {15'd0, irq}, 16'd1);
    // R14 read with write: only write acts, pending survives
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'hFF; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R14 read suppressed", {15'd0, irq}, 16'd1);
    rd(3'd2, 8'h02, "R13 id write ignored");
    rd(3'd5, 8'h60, "R8 empty bits stay");

    // R9 R10 receive
    rx(8'hC3, 1'b0);
    chk("R9 ready low", {15'd0, rx_ready}, 16'd0);
    chk("R5 irq on receive", {15'd0, irq}, 16'd1);
    rd(3'd2, 8'h04, "R4 receive id");
    rd(3'd5, 8'h61, "R9 data ready");
    rx(8'h11, 1'b0);
    rd(3'd0, 8'hC3, "R9 full holder ignores input");
    chk("R10 ready again", {15'd0, rx_ready}, 16'd1);
    rd(3'd5, 8'h60, "R10 data ready cleared");
    chk("R5 irq low", {15'd0, irq}, 16'd0);

    // R4 R6 priority with both sources
    wr(3'd0, 8'h00);
    rx(8'h77, 1'b0);
    rd(3'd2, 8'h04, "R4 receive wins");
    rd(3'd0, 8'h77, "R9 second byte");
    rd(3'd2, 8'h02, "R6 pending kept by 0x04 read");
    rd(3'd2, 8'h01, "R6 cleared");

    // R9 R10 break
    rx(8'hEE, 1'b1);
    rd(3'd5, 8'h71, "R9 break status");
    rd(3'd0, 8'h00, "R9 break loads zero");
    rd(3'd5, 8'h60, "R10 break cleared");

    // R4 enable gating, R6 no clear on 0x01
    wr(3'd1, 8'h00);
    rx(8'h99, 1'b0);
    chk("R4 masked irq", {15'd0, irq}, 16'd0);
    rd(3'd2, 8'h01, "R4 masked id");
    wr(3'd1, 8'h02);
    rd(3'd2, 8'h02, "R7 enable write arms");
    rd(3'd0, 8'h99, "R9 masked byte kept");

    // R13 ignored writes
    wr(3'd5, 8'h00);
    rd(3'd5, 8'h60, "R13 status write ignored");
    wr(3'd6, 8'h00);
    rd(3'd6, 8'hB0, "R13 modem status write ignored");
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h01, "R13 id write ignored");

    repeat (2) @(negedge clk);
    chk("R14 scoreboard drained", sb.size(), 16'd0);
    finish_run();
  end
endmodule